// File: doc/BRIEF.md
# Count/Compare Timer Interrupt Unit

This block keeps a 32-bit up-counter that advances once per enable tick (each tick standing for one period of a fixed 100 MHz time base) and a 32-bit compare register. When an increment carries the counter onto the compare value, the block sets a timer-pending bit at position 15 of a 32-bit cause word and raises a level interrupt request. The request stays up until software writes the compare register, which is the only acknowledge. A write to the count register moves the counter but leaves the compare value and any pending request as they were.

A match is detected only on an increment, never on a write. A write that leaves count equal to compare therefore signals nothing, and the next match comes only after the counter has wrapped all the way round. After reset the counter holds 1 and compare holds 0, so the first request follows the first wrap to zero.

The pending logic is a two-state machine. In state `ST_ARMED` no request is pending. The transition `MATCH` goes from `ST_ARMED` to `ST_PENDING` on a counted match with no compare write. The transition `ACK` goes from `ST_PENDING` to `ST_ARMED` on a compare write. `HOLD` is the self-loop in either state when neither of those conditions holds, and that includes further matches while the machine is in `ST_PENDING`. A compare write in `ST_ARMED` keeps the machine in `ST_ARMED` even if a match lands in the same cycle.

Top module: `cmp_timer_irq`

## Requirements
- R1: After reset the count read port shows 0x00000001, the cause word is 0 and the interrupt request is low. The compare value is 0 at that point.
- R2: At each clock edge with the tick enable high and no count write, the count goes up by one. With the tick enable low and no count write, the count holds.
- R3: An increment from 0xFFFFFFFF gives 0x00000000 and has no effect other than the match test on the new value.
- R4: When an increment produces a value equal to the compare register, the interrupt request and cause bit 15 are high from the next clock edge on, unless R10 applies.
- R5: Only bit 15 of the cause word is ever set (cause is 0x00008000 or 0x00000000), and the interrupt request always equals cause bit 15.
- R6: A compare write loads the new compare value. From the following edge the cause word is 0 and the interrupt request is low.
- R7: A count write loads the written value at the next edge, in place of any increment in the same cycle. It does not change the compare value and does not clear a pending request.
- R8: A count write that makes count equal to compare raises no request. Later increments match only when the count comes round to the compare value again.
- R9: Once pending, the request stays high through any number of further matches and count writes, until a compare write.
- R10: If a compare write and a matching increment occur in the same cycle, the request is low afterwards.
- R11: With compare left at its reset value of 0, the first request appears on the increment that wraps the count to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter advance enable, one per time-base period |
| cnt_wr | input | 1 | Count register write strobe |
| cnt_wdata | input | 32 | Value for a count write |
| cmp_wr | input | 1 | Compare register write strobe, also the acknowledge |
| cmp_wdata | input | 32 | Value for a compare write |
| cnt_rdata | output | 32 | Current count value |
| cause_out | output | 32 | Cause word with the timer-pending bit at position 15 |
| irq_req | output | 1 | Level interrupt request |

## Verification
Every result in this block is registered once. A tick, count write or compare write applied before edge k shows on `cnt_rdata`, `cause_out` and `irq_req` right after edge k, and on no earlier edge. The bench drives inputs on the falling edge, lets the rising edge pass, and samples 1 ns later. It steps a bench-side reference model at the same point in the cycle, so each comparison lines up with the edge that made the change. Directed steps check exact values at the wrap, at collisions between a write and a tick, and at the sticky pending state. Random steps aim compare writes a few ticks ahead of the count so that matches happen often.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Pending-request state of the timer interrupt.
    typedef enum logic [0:0] {
        ST_ARMED   = 1'b0,
        ST_PENDING = 1'b1
    } irq_st_e;

    // Named transitions, for readability of the next-state logic.
    typedef enum logic [1:0] {
        TR_HOLD  = 2'd0,
        TR_MATCH = 2'd1,
        TR_ACK   = 2'd2
    } irq_tr_e;

endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int          CW        = 32,
    parameter logic [CW-1:0] RST_VAL = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] cnt_q,
    output logic          step_o,
    output logic [CW-1:0] cnt_inc_o
);

    logic [CW-1:0] cnt_d;

    // A write takes the place of an increment in the same cycle.
    assign step_o    = tick_en && !wr_en;
    assign cnt_inc_o = cnt_q + {{(CW-1){1'b0}}, 1'b1};

    always_comb begin
        cnt_d = cnt_q;
        if (wr_en)
            cnt_d = wr_data;
        else if (tick_en)
            cnt_d = cnt_inc_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= RST_VAL;
        else
            cnt_q <= cnt_d;
    end

    // R2: one step per tick, hold otherwise
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !wr_en) |=> (cnt_q == $past(cnt_q) + 1'b1));
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !wr_en) |=> $stable(cnt_q));
    // R3: wrap to zero
    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !wr_en && (cnt_q == {CW{1'b1}})) |=> (cnt_q == '0));
    // R7: write wins over tick
    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cnt_q == $past(wr_data)));

endmodule

// File: rtl/tmr_match.sv
module tmr_match #(
    parameter int            CW      = 32,
    parameter logic [CW-1:0] RST_VAL = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  logic [CW-1:0] cnt_inc_i,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_data,
    output logic          hit_o
);

    logic [CW-1:0] cmp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cmp_q <= RST_VAL;
        else if (wr_en)
            cmp_q <= wr_data;
    end

    // A match exists only on a counted step, never on a write.
    assign hit_o = step_i && (cnt_inc_i == cmp_q);

    // R6: compare write loads the new value
    p_cmp_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cmp_q == $past(wr_data)));
    // R7: compare unchanged without a compare write
    p_cmp_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cmp_q));

endmodule

// File: rtl/tmr_irq_fsm.sv
module tmr_irq_fsm
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    input  logic ack_i,
    output logic pend_o
);

    irq_st_e st_q, st_d;
    irq_tr_e tr;

    always_comb begin
        tr = TR_HOLD;
        unique case (st_q)
            ST_ARMED:   if (hit_i && !ack_i) tr = TR_MATCH;
            ST_PENDING: if (ack_i)           tr = TR_ACK;
            default:                         tr = TR_HOLD;
        endcase
    end

    always_comb begin
        st_d = st_q;
        unique case (tr)
            TR_MATCH: st_d = ST_PENDING;
            TR_ACK:   st_d = ST_ARMED;
            default:  st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_ARMED;
        else
            st_q <= st_d;
    end

    always_comb begin
        unique case (st_q)
            ST_PENDING: pend_o = 1'b1;
            default:    pend_o = 1'b0;
        endcase
    end

    // R4: a match without acknowledge makes the request pending
    p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && !ack_i) |=> pend_o);
    // R6 and R10: acknowledge always leaves the request clear
    p_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> !pend_o);
    // R9: sticky until acknowledged
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !ack_i) |=> pend_o);
    p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_o && !hit_i) |=> !pend_o);

endmodule

// File: rtl/cmp_timer_irq.sv
module cmp_timer_irq #(
    parameter int CNT_W    = 32,
    parameter int CAUSE_W  = 32,
    parameter int PEND_BIT = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic               cnt_wr,
    input  logic [CNT_W-1:0]   cnt_wdata,
    input  logic               cmp_wr,
    input  logic [CNT_W-1:0]   cmp_wdata,
    output logic [CNT_W-1:0]   cnt_rdata,
    output logic [CAUSE_W-1:0] cause_out,
    output logic               irq_req
);

    localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(1);
    localparam logic [CNT_W-1:0] CMP_RST = '0;

    logic             step;
    logic [CNT_W-1:0] cnt_inc;
    logic             hit;
    logic             pend;

    tmr_counter #(.CW(CNT_W), .RST_VAL(CNT_RST)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .wr_en     (cnt_wr),
        .wr_data   (cnt_wdata),
        .cnt_q     (cnt_rdata),
        .step_o    (step),
        .cnt_inc_o (cnt_inc)
    );

    tmr_match #(.CW(CNT_W), .RST_VAL(CMP_RST)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step),
        .cnt_inc_i (cnt_inc),
        .wr_en     (cmp_wr),
        .wr_data   (cmp_wdata),
        .hit_o     (hit)
    );

    tmr_irq_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit_i  (hit),
        .ack_i  (cmp_wr),
        .pend_o (pend)
    );

    for (genvar b = 0; b < CAUSE_W; b++) begin : g_cause
        if (b == PEND_BIT) begin : g_pend
            assign cause_out[b] = pend;
        end else begin : g_zero
            assign cause_out[b] = 1'b0;
        end
    end

    assign irq_req = pend;

    // R5: no cause bit other than the pending one
    p_only_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cause_out) == (irq_req ? 1 : 0));
    // R7: a count write alone never drops a pending request
    p_cntwr_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && !cmp_wr && irq_req) |=> irq_req);

endmodule

// File: tb/cmp_timer_irq_test.sv
module cmp_timer_irq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        cnt_wr = 1'b0;
    logic [31:0] cnt_wdata = '0;
    logic        cmp_wr = 1'b0;
    logic [31:0] cmp_wdata = '0;
    logic [31:0] cnt_rdata;
    logic [31:0] cause_out;
    logic        irq_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference model
    logic [31:0] m_cnt, m_cmp;
    logic        m_pend;

    always #4 clk = ~clk;

    cmp_timer_irq uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
        .cnt_rdata(cnt_rdata), .cause_out(cause_out), .irq_req(irq_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_cause(input logic p);
        return p ? 32'h0000_8000 : 32'h0;
    endfunction

    // Apply one cycle of stimulus and advance the model at the same edge.
    task automatic cyc(input logic t, input logic pw, input logic [31:0] pd,
                       input logic cw, input logic [31:0] cd);
        logic hit;
        @(negedge clk);
        tick_en = t; cnt_wr = pw; cnt_wdata = pd; cmp_wr = cw; cmp_wdata = cd;
        @(posedge clk);
        hit = t && !pw && ((m_cnt + 32'd1) == m_cmp);
        if (cw)       m_pend = 1'b0;
        else if (hit) m_pend = 1'b1;
        m_cnt = pw ? pd : (t ? m_cnt + 32'd1 : m_cnt);
        if (cw) m_cmp = cd;
        #1;
    endtask

    task automatic model_chk(input string tag);
        chk({tag, " count"}, cnt_rdata, m_cnt);
        chk({tag, " irq"}, {31'b0, irq_req}, {31'b0, m_pend});
        chk({tag, " cause"}, cause_out, exp_cause(m_pend));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_cnt = 32'd1; m_cmp = 32'd0; m_pend = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 count", cnt_rdata, 32'd1);
        chk("R1 cause", cause_out, 32'd0);
        chk("R1 irq", {31'b0, irq_req}, 32'd0);

        // R2 hold without tick, then advance
        repeat (3) cyc(0, 0, 0, 0, 0);
        chk("R2 hold", cnt_rdata, 32'd1);
        repeat (5) cyc(1, 0, 0, 0, 0);
        chk("R2 step", cnt_rdata, 32'd6);

        // R11 / R3 first match at wrap with reset compare 0
        cyc(0, 1, 32'hFFFF_FFFE, 0, 0);
        chk("R7 load", cnt_rdata, 32'hFFFF_FFFE);
        cyc(1, 0, 0, 0, 0);
        chk("R11 no early irq", {31'b0, irq_req}, 32'd0);
        cyc(1, 0, 0, 0, 0);
        chk("R3 wrap", cnt_rdata, 32'd0);
        chk("R11 irq at wrap", {31'b0, irq_req}, 32'd1);
        chk("R5 cause", cause_out, 32'h0000_8000);

        // R9 / R7 sticky through count write and second match
        cyc(0, 1, 32'hFFFF_FFFF, 0, 0);
        chk("R7 count write keeps irq", {31'b0, irq_req}, 32'd1);
        cyc(1, 0, 0, 0, 0);
        chk("R9 sticky", {31'b0, irq_req}, 32'd1);

        // R6 compare write acknowledges
        cyc(1, 0, 0, 1, 32'd100);
        chk("R6 ack irq", {31'b0, irq_req}, 32'd0);
        chk("R6 ack cause", cause_out, 32'd0);

        // R8 write count equal to compare: no request
        cyc(0, 1, 32'd100, 0, 0);
        repeat (5) cyc(1, 0, 0, 0, 0);
        chk("R8 no match on write", {31'b0, irq_req}, 32'd0);
        chk("R8 count", cnt_rdata, 32'd105);

        // R4 normal match
        cyc(0, 1, 32'd200, 1, 32'd203);
        cyc(1, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0);
        chk("R4 before match", {31'b0, irq_req}, 32'd0);
        cyc(1, 0, 0, 0, 0);
        chk("R4 match", {31'b0, irq_req}, 32'd1);

        // R10 compare write collides with matching tick
        cyc(0, 1, 32'd300, 1, 32'd302);
        cyc(1, 0, 0, 0, 0);
        chk("R10 armed", {31'b0, irq_req}, 32'd0);
        cyc(1, 0, 0, 1, 32'd500);
        chk("R10 write wins", {31'b0, irq_req}, 32'd0);
        chk("R10 count", cnt_rdata, 32'd302);

        // R7 count write with tick in same cycle
        cyc(1, 1, 32'd499, 0, 0);
        chk("R7 write over tick", cnt_rdata, 32'd499);
        cyc(1, 0, 0, 0, 0);
        chk("R7 compare kept", {31'b0, irq_req}, 32'd1);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic t, pw, cw;
            logic [31:0] pd, cd;
            t  = ($urandom_range(0, 9) < 8);
            pw = ($urandom_range(0, 19) == 0);
            cw = ($urandom_range(0, 14) == 0);
            pd = ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFF0 + $urandom_range(0, 15) : $urandom;
            cd = m_cnt + $urandom_range(0, 12);
            cyc(t, pw, pd, cw, cd);
            model_chk("R2/R4/R5/R6/R9 random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule